// File: doc/BRIEF.md
# Index-Addressed Level Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt lines and presents them to a single processor as one request line. Each line passes through two gates: an enable bit that turns the source on, and a mask bit that blocks it. Software changes either bit by writing the number of a source to a dedicated "set" or "clear" address. It never has to read, modify and write back a bitmap, so two pieces of software touching different sources cannot overwrite each other's changes.

The processor services interrupts by reading an acknowledge address. That read returns the number of the lowest-numbered source that is currently eligible, or the reserved code 1023 when nothing is eligible. Software loops on this read until it sees 1023. A control address reports how many sources are built in.

The register port is word-addressed and has one-cycle read latency. A source is eligible while its input is high, its enable bit is set and its mask bit is clear.

Top module: `idx_irq_ctrl`

## Requirements
- R1: Out of reset, every enable bit is 0 and every mask bit is 1. `irq_out` is low and an acknowledge read returns 1023.
- R2: Writing k to word address 12 sets the enable bit of source k. Writing k to word address 13 clears it.
- R3: Writing k to word address 18 sets the mask bit of source k, which blocks it. Writing k to word address 19 clears the mask bit.
- R4: `irq_out` is high in the cycle after any source is eligible (input high, enabled, unmasked) and low in the cycle after none is.
- R5: A read of word address 17 returns, one cycle later, the lowest-numbered eligible source in bits [9:0], with bits [31:10] zero.
- R6: When no source is eligible, the acknowledge read returns 1023.
- R7: A read of word address 0 returns `N_SRC` in bits [11:2], with all other bits zero.
- R8: A set or clear write whose whole data word is `N_SRC` or greater changes no enable or mask bit.
- R9: Reading the acknowledge address changes no state. A source stops being reported once its input line goes low.
- R10: A read of any other word address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level interrupt inputs, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data (source number for set/clear) |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Registered interrupt request to the CPU |

## Verification
A write takes effect on the enable and mask bits at the clock edge that samples it. `irq_out` follows one edge later, because it is registered from the eligible set. Read data is captured at the edge that samples `bus_rd` and reflects every write from earlier edges. The bench drives on falling edges and issues its acknowledge read straight after each write. It then checks both the read data and `irq_out` at the falling edge after the read, which is the first point where both results are due.

// File: rtl/idx_irq_pkg.sv
package idx_irq_pkg;
  localparam int IDX_W      = 10;
  localparam int NONE_CODE  = 1023;
  // word addresses (byte offset / 4)
  localparam int A_CTRL     = 0;
  localparam int A_EN_SET   = 12;
  localparam int A_EN_CLR   = 13;
  localparam int A_ACK      = 17;
  localparam int A_MSK_SET  = 18;
  localparam int A_MSK_CLR  = 19;
endpackage

// File: rtl/idx_irq_bitvec.sv
module idx_irq_bitvec #(
  parameter int N      = 64,
  parameter int DW     = 32,
  parameter bit RST_ONE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] idx_i,
  output logic [N-1:0]  bits_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic hit;
    assign hit = (idx_i == DW'(i));
    always_ff @(posedge clk) begin
      if (rst)               bits_o[i] <= RST_ONE;
      else if (set_en && hit) bits_o[i] <= 1'b1;
      else if (clr_en && hit) bits_o[i] <= 1'b0;
    end
  end

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((set_en || clr_en) && idx_i >= DW'(N)) |=> $stable(bits_o)); // R8
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (set_en && idx_i < DW'(N)) |=> |(bits_o & (N'(1) << $past(idx_i)))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_en && idx_i < DW'(N)) |=> !(|(bits_o & (N'(1) << $past(idx_i))))); // R3
endmodule

// File: rtl/idx_irq_select.sv
module idx_irq_select #(
  parameter int N     = 64,
  parameter int IW    = 10,
  parameter int NONE  = 1023
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = IW'(NONE);
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = IW'(i);
    end
  end

  AST_NONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(|elig_i) |-> idx_o == IW'(NONE)); // R6
  AST_PICK_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (|elig_i) |-> |(elig_i & (N'(1) << idx_o))); // R5
  AST_PICK_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (|elig_i) |-> ((elig_i & ((N'(1) << idx_o) - N'(1))) == '0)); // R5
endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl
  import idx_irq_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam logic [DATA_W-1:0] CTRL_VAL = DATA_W'(N_SRC) << 2;

  logic [N_SRC-1:0] en_bits, msk_bits, elig;
  logic [IDX_W-1:0] ack_idx;

  idx_irq_bitvec #(.N(N_SRC), .DW(DATA_W), .RST_ONE(1'b0)) u_enable (
    .clk(clk), .rst(rst),
    .set_en(bus_wr && bus_addr == ADDR_W'(A_EN_SET)),
    .clr_en(bus_wr && bus_addr == ADDR_W'(A_EN_CLR)),
    .idx_i(bus_wdata), .bits_o(en_bits));

  idx_irq_bitvec #(.N(N_SRC), .DW(DATA_W), .RST_ONE(1'b1)) u_mask (
    .clk(clk), .rst(rst),
    .set_en(bus_wr && bus_addr == ADDR_W'(A_MSK_SET)),
    .clr_en(bus_wr && bus_addr == ADDR_W'(A_MSK_CLR)),
    .idx_i(bus_wdata), .bits_o(msk_bits));

  assign elig = src_i & en_bits & ~msk_bits;

  idx_irq_select #(.N(N_SRC), .IW(IDX_W), .NONE(NONE_CODE)) u_select (
    .clk(clk), .rst(rst), .elig_i(elig), .idx_o(ack_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_out <= |elig;
      if (bus_rd) begin
        if (bus_addr == ADDR_W'(A_CTRL))     bus_rdata <= CTRL_VAL;
        else if (bus_addr == ADDR_W'(A_ACK)) bus_rdata <= DATA_W'(ack_idx);
        else                                 bus_rdata <= '0;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !irq_out); // R1
  AST_ACK_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == ADDR_W'(A_ACK)) |-> bus_rdata[DATA_W-1:IDX_W] == '0); // R5
  AST_IRQ_VS_ACK: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == ADDR_W'(A_ACK) && !$past(rst)) |->
      (irq_out == (bus_rdata != DATA_W'(NONE_CODE)))); // R4
endmodule

// File: tb/test_idx_irq_ctrl.sv
module test_idx_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_irq_ctrl #(.N_SRC(N)) i_idx_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    addr = 6'(a); wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    addr = 6'(a); rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic expect_ack(input string req, input int exp_idx, input bit exp_irq);
    logic [31:0] v;
    rd_reg(17, v);
    chk(req, v, 32'(exp_idx));
    chk(req, 32'(irq), 32'(exp_irq));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    src = '1; @(negedge clk);
    expect_ack("R1 masked", 1023, 0);
    rd_reg(0, v); chk("R7 ctrl", v, 32'(N) << 2);
    rd_reg(5, v); chk("R10 other", v, 0);
  endtask

  task automatic t_enable;
    wr_reg(12, 5);  expect_ack("R3 still masked", 1023, 0);
    wr_reg(19, 5);  expect_ack("R4 R5 src5", 5, 1);
    wr_reg(13, 5);  expect_ack("R2 disabled", 1023, 0);
  endtask

  task automatic t_mask_order;
    wr_reg(12, 3); wr_reg(12, 7); wr_reg(19, 7);
    expect_ack("R5 only7", 7, 1);
    wr_reg(19, 3);  expect_ack("R5 lowest", 3, 1);
    wr_reg(18, 3);  expect_ack("R3 mask3", 7, 1);
  endtask

  task automatic t_out_of_range;
    wr_reg(18, 32'd71);      expect_ack("R8 mask71", 7, 1);
    wr_reg(13, 32'h0001_0007); expect_ack("R8 clr big", 7, 1);
    wr_reg(18, 32'd64);      expect_ack("R8 mask64", 7, 1);
  endtask

  task automatic t_level_and_read;
    expect_ack("R9 read1", 7, 1);
    expect_ack("R9 read2", 7, 1);
    src[7] = 1'b0; @(negedge clk);
    expect_ack("R9 level low", 1023, 0);
    src[7] = 1'b1; @(negedge clk);
    expect_ack("R9 level high", 7, 1);
  endtask

  task automatic t_top_source;
    wr_reg(18, 7);
    wr_reg(12, 63); wr_reg(19, 63);
    expect_ack("R5 top", 63, 1);
    wr_reg(18, 63); expect_ack("R6 none", 1023, 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_mask_order();
    t_out_of_range();
    t_level_and_read();
    t_top_source();
    finish_run();
  end
endmodule